// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block couples two 18-bit buses, side A and side B, through two independent one-way paths: one carries A toward B, the other carries B toward A. Each path owns a single storage element that acts either as a transparent latch or as an edge-triggered register. Four controls govern a path: a pass control that makes it transparent, a strobe whose rising edge loads the register, an active-low strobe enable that lets strobe edges through, and an active-low drive control that turns that path's output driver on.

The design runs on one system clock with a synchronous active-high reset. The strobe of each path is sampled on that clock. A rising edge is a strobe seen low at one system clock edge and high at the next. While a path is transparent, its output follows the opposite input combinationally. The storage keeps tracking that input, so the value passing through is kept when the pass control drops. Each bus side is shown as a separate input, output and output-enable, so that a tri-state pad can be built around it.

Top module: `bus_xcvr_lr`

## Requirements
- R1: While `ab_pass` is 1, `b_o` equals `a_i` in the same cycle, combinationally.
- R2: With `ab_pass` 0 and `ab_strobe_en_n` 0, a strobe rising edge loads `a_i` into storage at that system clock edge. A rising edge means `ab_strobe` was 0 at the previous clock edge and is 1 at this one. After the edge, `b_o` shows the loaded value.
- R3: While `ab_strobe_en_n` is 1 and `ab_pass` is 0, strobe edges have no effect, and `b_o` keeps its stored value.
- R4: While `ab_pass` is 0 and `ab_strobe` stays steady (high or low), `b_o` keeps its stored value whatever `a_i` does.
- R5: When `ab_pass` falls, `b_o` keeps the value that `a_i` had at the last system clock edge where `ab_pass` was 1.
- R6: `b_oe` is 1 exactly when `ab_drive_n` is 0 and reset is inactive. When `b_oe` is 0, side B is high impedance.
- R7: While `rst` is 1, both `a_oe` and `b_oe` are 0. A reset clock edge clears both stored values to zero.
- R8: The B-to-A path behaves the same way from `b_i` to `a_o`, using `ba_pass`, `ba_strobe`, `ba_strobe_en_n` and `ba_drive_n`. `a_oe` is 1 exactly when `ba_drive_n` is 0 and reset is inactive.
- R9: With both drive controls active and both paths transparent, `b_o` equals `a_i` and `a_o` equals `b_i` at the same time, with no interaction between the paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 18 | Side A data in |
| a_o | output | 18 | Side A data out (from B-to-A path) |
| a_oe | output | 1 | Side A driver enable |
| b_i | input | 18 | Side B data in |
| b_o | output | 18 | Side B data out (from A-to-B path) |
| b_oe | output | 1 | Side B driver enable |
| ab_pass | input | 1 | A-to-B transparent mode |
| ab_strobe | input | 1 | A-to-B load strobe (rising edge) |
| ab_strobe_en_n | input | 1 | A-to-B strobe enable, active low |
| ab_drive_n | input | 1 | A-to-B driver control, active low |
| ba_pass | input | 1 | B-to-A transparent mode |
| ba_strobe | input | 1 | B-to-A load strobe (rising edge) |
| ba_strobe_en_n | input | 1 | B-to-A strobe enable, active low |
| ba_drive_n | input | 1 | B-to-A driver control, active low |

## Verification
The bench targets the moment the pass control drops. A design that only loads on strobe edges would then output stale data instead of the value last passed through. It holds the strobe high across several cycles; a level-sensitive load would then keep following the input instead of holding it. It toggles the strobe while its enable is inactive, which a design that ignores the enable would turn into a load. It also runs both paths at once, transparent and driving, so that swapped or cross-coupled paths show up as wrong data on one side.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int NUM_DIR = 2;

  typedef enum logic [0:0] {
    DIR_AB = 1'b0,
    DIR_BA = 1'b1
  } dir_e;

  typedef struct packed {
    logic pass;
    logic strobe;
    logic strobe_en_n;
    logic drive_n;
  } path_ctl_t;
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pass,
  input  logic         rise,
  input  logic         strobe_en_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] held_q;
  logic         load;

  assign load = pass | (rise & ~strobe_en_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else if (load) begin
      held_q <= din;
    end
  end

  assign dout = pass ? din : held_q;
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive (
  input  logic rst,
  input  logic drive_n,
  output logic oe
);
  assign oe = ~rst & ~drive_n;
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int W = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  xcvr_pkg::path_ctl_t ctl,
  input  logic [W-1:0]        din,
  output logic [W-1:0]        dout,
  output logic                oe
);
  logic rise;

  xcvr_edge_det u_edge (
    .clk   (clk),
    .level (ctl.strobe),
    .rise  (rise)
  );

  xcvr_store #(.W(W)) u_store (
    .clk         (clk),
    .rst         (rst),
    .pass        (ctl.pass),
    .rise        (rise),
    .strobe_en_n (ctl.strobe_en_n),
    .din         (din),
    .dout        (dout)
  );

  xcvr_drive u_drive (
    .rst     (rst),
    .drive_n (ctl.drive_n),
    .oe      (oe)
  );
endmodule

// File: rtl/bus_xcvr_lr.sv
module bus_xcvr_lr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe,
  input  logic         ab_pass,
  input  logic         ab_strobe,
  input  logic         ab_strobe_en_n,
  input  logic         ab_drive_n,
  input  logic         ba_pass,
  input  logic         ba_strobe,
  input  logic         ba_strobe_en_n,
  input  logic         ba_drive_n
);
  import xcvr_pkg::*;

  path_ctl_t            ctl  [NUM_DIR];
  logic [W-1:0]         din  [NUM_DIR];
  logic [W-1:0]         dout [NUM_DIR];
  logic [NUM_DIR-1:0]   oe;

  assign ctl[DIR_AB] = '{pass: ab_pass, strobe: ab_strobe,
                         strobe_en_n: ab_strobe_en_n, drive_n: ab_drive_n};
  assign ctl[DIR_BA] = '{pass: ba_pass, strobe: ba_strobe,
                         strobe_en_n: ba_strobe_en_n, drive_n: ba_drive_n};
  assign din[DIR_AB] = a_i;
  assign din[DIR_BA] = b_i;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_path
    xcvr_path #(.W(W)) u_path (
      .clk  (clk),
      .rst  (rst),
      .ctl  (ctl[d]),
      .din  (din[d]),
      .dout (dout[d]),
      .oe   (oe[d])
    );
  end

  assign b_o  = dout[DIR_AB];
  assign b_oe = oe[DIR_AB];
  assign a_o  = dout[DIR_BA];
  assign a_oe = oe[DIR_BA];
endmodule

// File: rtl/bus_xcvr_lr_chk.sv
module bus_xcvr_lr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_i,
  input logic [W-1:0] a_o,
  input logic         a_oe,
  input logic [W-1:0] b_i,
  input logic [W-1:0] b_o,
  input logic         b_oe,
  input logic         ab_pass,
  input logic         ab_strobe,
  input logic         ab_strobe_en_n,
  input logic         ab_drive_n,
  input logic         ba_pass,
  input logic         ba_strobe,
  input logic         ba_strobe_en_n,
  input logic         ba_drive_n
);
  p_pass_follow_r1: assert property (@(posedge clk) disable iff (rst)
    ab_pass |-> b_o == a_i);

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(!ab_pass && !ab_strobe_en_n && ab_strobe) && !$past(ab_strobe, 2)
     && !$past(rst) && !ab_pass) |-> b_o == $past(a_i));

  p_hold_disabled_r3: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && $past(!ab_pass) && $past(ab_strobe_en_n) && !$past(rst))
    |-> $stable(b_o));

  p_hold_steady_r4: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && $past(!ab_pass) && ($past(ab_strobe) == $past(ab_strobe, 2))
     && !$past(rst)) |-> $stable(b_o));

  p_pass_fall_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(ab_pass) && !$past(rst)) |-> b_o == $past(a_i));

  p_drive_r6: assert property (@(posedge clk) disable iff (rst)
    b_oe == !ab_drive_n);

  p_reset_quiet_r7: assert property (@(posedge clk)
    rst |-> (!a_oe && !b_oe));

  p_ba_follow_r8: assert property (@(posedge clk) disable iff (rst)
    ba_pass |-> a_o == b_i);

  p_ba_drive_r8: assert property (@(posedge clk) disable iff (rst)
    a_oe == !ba_drive_n);

  p_ba_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!ba_pass && $past(!ba_pass) && $past(ba_strobe_en_n) && !$past(rst))
    |-> $stable(a_o));
endmodule

bind bus_xcvr_lr bus_xcvr_lr_chk #(.W(W)) u_chk (.*);

// File: tb/bus_xcvr_lr_test.sv
`timescale 1ns/1ps
module bus_xcvr_lr_test;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] a_o, b_o;
  logic         a_oe, b_oe;
  logic ab_pass = 1'b0, ab_strobe = 1'b0, ab_strobe_en_n = 1'b1, ab_drive_n = 1'b1;
  logic ba_pass = 1'b0, ba_strobe = 1'b0, ba_strobe_en_n = 1'b1, ba_drive_n = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;

  // bench-side expected state
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic         ps_ab = 1'b0, ps_ba = 1'b0;

  always #2 clk = ~clk;

  bus_xcvr_lr #(.W(W)) uut (.*);

  function automatic logic [W-1:0] next_store(logic r, logic pass, logic en_n,
                                              logic s, logic ps,
                                              logic [W-1:0] d, logic [W-1:0] cur);
    if (r) return '0;
    if (pass) return d;
    if (!en_n && s && !ps) return d;
    return cur;
  endfunction

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %05h expected %05h", req, got, exp);
    end
  endtask

  // one system clock step with bench model update, sampled 1 ns after the edge
  task automatic cyc();
    m_ab  = next_store(rst, ab_pass, ab_strobe_en_n, ab_strobe, ps_ab, a_i, m_ab);
    m_ba  = next_store(rst, ba_pass, ba_strobe_en_n, ba_strobe, ps_ba, b_i, m_ba);
    ps_ab = ab_strobe;
    ps_ba = ba_strobe;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_model(string tag);
    chk({tag, " R1/R2/R3/R4 b_o"}, b_o, ab_pass ? a_i : m_ab);
    chk({tag, " R8 a_o"}, a_o, ba_pass ? b_i : m_ba);
    chk({tag, " R6 b_oe"}, W'(b_oe), W'(!rst && !ab_drive_n));
    chk({tag, " R8 a_oe"}, W'(a_oe), W'(!rst && !ba_drive_n));
  endtask

  initial begin
    #(100000 * 4);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R7: reset clears and keeps drivers off even with drive requested
    ab_drive_n = 1'b0; ba_drive_n = 1'b0;
    cyc(); cyc();
    chk("R7 b_o after reset", b_o, '0);
    chk("R7 a_o after reset", a_o, '0);
    chk("R7 b_oe in reset", W'(b_oe), '0);
    chk("R7 a_oe in reset", W'(a_oe), '0);
    rst = 1'b0;
    cyc();
    // R6 driver control
    chk("R6 b_oe active", W'(b_oe), W'(1));
    ab_drive_n = 1'b1; #1;
    chk("R6 b_oe off", W'(b_oe), '0);
    ab_drive_n = 1'b0;
    // R1 transparent
    ab_pass = 1'b1; a_i = 18'h2AAAA; #1;
    chk("R1 follow", b_o, 18'h2AAAA);
    a_i = 18'h15555; #1;
    chk("R1 follow change", b_o, 18'h15555);
    cyc();
    // R5 pass falls, value retained
    ab_pass = 1'b0; a_i = 18'h3FFFF; #1;
    chk("R5 retained", b_o, 18'h15555);
    cyc();
    chk("R5 retained after edge", b_o, 18'h15555);
    // R2 capture on strobe rise
    ab_strobe_en_n = 1'b0; ab_strobe = 1'b0; cyc();
    ab_strobe = 1'b1; a_i = 18'h0F0F0; cyc();
    chk("R2 capture", b_o, 18'h0F0F0);
    // R4 strobe held high, then low
    a_i = 18'h12345; cyc(); cyc();
    chk("R4 steady high", b_o, 18'h0F0F0);
    ab_strobe = 1'b0; cyc(); cyc();
    chk("R4 steady low", b_o, 18'h0F0F0);
    // R3 strobe enable inactive
    ab_strobe_en_n = 1'b1; ab_strobe = 1'b1; a_i = 18'h0BEEF; cyc();
    ab_strobe = 1'b0; cyc(); ab_strobe = 1'b1; cyc();
    chk("R3 ignored edge", b_o, 18'h0F0F0);
    // R8 mirrored path
    ba_strobe_en_n = 1'b0; ba_strobe = 1'b0; b_i = 18'h2468A; cyc();
    ba_strobe = 1'b1; cyc();
    b_i = 18'h11111; #1;
    chk("R8 capture", a_o, 18'h2468A);
    ba_pass = 1'b1; #1;
    chk("R8 follow", a_o, 18'h11111);
    // R9 both paths transparent and driving
    ab_pass = 1'b1; ba_pass = 1'b1; ab_drive_n = 1'b0; ba_drive_n = 1'b0;
    a_i = 18'h3C3C3; b_i = 18'h03C3C; #1;
    chk("R9 b_o", b_o, 18'h3C3C3);
    chk("R9 a_o", a_o, 18'h03C3C);
    chk("R9 both oe", W'({a_oe, b_oe}), W'(2'b11));
    cyc();
    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      ab_pass        = ($urandom % 5) == 0;
      ba_pass        = ($urandom % 5) == 0;
      ab_strobe      = $urandom % 2;
      ba_strobe      = $urandom % 2;
      ab_strobe_en_n = ($urandom % 3) == 0;
      ba_strobe_en_n = ($urandom % 3) == 0;
      ab_drive_n     = $urandom % 2;
      ba_drive_n     = $urandom % 2;
      a_i            = W'($urandom);
      b_i            = W'($urandom);
      rst            = ($urandom % 200) == 0;
      cyc();
      chk_model("random");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule